// File: doc/BRIEF.md
# GPIO Bank Controller with Edge-Detect Interrupts

This block is a general-purpose I/O controller. It handles a configurable number of pins, grouped into banks of 32. A simple single-cycle register bus reaches every bank. For each pin, software chooses the direction, drives the output level through separate atomic set and clear writes, reads the synchronised input level, and selects a 2-bit alternate function. The function code only leaves the block on a port. The pad multiplexing itself sits outside.

Each input passes through a two-flop synchroniser before edge detection. Each pin has its own rising-edge and falling-edge enables. An enabled edge sets a sticky status bit, and software clears that bit by writing a one to it. Pin 0 and pin 1 each drive a private interrupt line. The status bits of every higher pin are merged onto one shared line. When the pin count is not a multiple of 32, the last bank is partial, and its missing bits read as zero.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: The word address is {bank[1:0], reg[3:0]}. Pin n sits in bank n/32 at bit n%32. A bank that holds no pins reads as zero on every register.
- R2: A write to reg code 2 (set) drives pin_out high for each 1 bit. A write to reg code 3 (clear) drives it low for each 1 bit. Zero bits leave pins unchanged. Both codes read back the output latch.
- R3: Reg code 1 is the direction register. A bit of 1 makes pin_oe high (output) and a bit of 0 makes the pin an input.
- R4: Reg code 0 reads the pin level after a two-flop synchroniser, so a pin change is visible after the second clock edge. Writes to code 0 are ignored.
- R5: Reg code 7 holds the 2-bit function fields of bank pins 0-15, and reg code 8 holds those of bank pins 16-31. The field of pin k sits at bits [2*(k%16)+1 : 2*(k%16)], and it drives pin_fn[2n+1:2n] for pin n.
- R6: Reg code 4 enables rising-edge detection and reg code 5 enables falling-edge detection. An enabled edge on a pin that changes before clock edge 1 sets its status bit at clock edge 3. With both enables set, either edge is detected.
- R7: Reg code 6 is the sticky status register. Writing 1 to a bit clears it, and writing 0 has no effect.
- R8: If an enabled edge and a clear of the same status bit meet in the same cycle, the bit stays set.
- R9: irq_pin0 and irq_pin1 follow status bits 0 and 1 one clock later. irq_shared is the registered OR of the status bits of pins 2 and above.
- R10: In a partial last bank, bits at or above the pin count read 0 and ignore writes.
- R11: A synchronous reset clears direction, output, enables, status, function and interrupts to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Word address {bank, reg code} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enable (direction) |
| pin_fn | output | 2*NUM_PINS | Alternate-function select, 2 bits per pin |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Combined interrupt for pins 2 and above |

## Verification
The assertions rely on two assumptions about the inputs. First, a status clear and a set or clear of the output latch arrive as single-cycle writes whose data is stable at the clock edge. Second, reset is held long enough to clear the synchroniser before any edge enable is written. The stimulus changes pin inputs and bus signals only on the falling clock edge, and it keeps every edge enable at zero until reset has been released. Directed sequences place an edge on the same cycle as its clear. A random phase then mixes writes to every register code, including absent banks and the missing bits of the partial bank.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int BANK_BITS  = 32;
    localparam int BANK_SEL_W = 2;
    localparam int REG_CODE_W = 4;
    localparam int ADDR_W     = BANK_SEL_W + REG_CODE_W;
    localparam int FN_BITS    = 2;
    localparam int FN_SLOTS   = BANK_BITS / 2;

    typedef enum logic [REG_CODE_W-1:0] {
        REG_LEVEL = 4'd0,
        REG_DIR   = 4'd1,
        REG_SET   = 4'd2,
        REG_CLR   = 4'd3,
        REG_RISE  = 4'd4,
        REG_FALL  = 4'd5,
        REG_STAT  = 4'd6,
        REG_FN_LO = 4'd7,
        REG_FN_HI = 4'd8
    } reg_code_e;

    typedef struct packed {
        logic                 wr;
        reg_code_e            code;
        logic [BANK_BITS-1:0] data;
    } bank_req_t;

    // Number of populated pins in bank b for a device with np pins.
    function automatic int bank_width(int np, int b);
        int rem;
        rem = np - b * BANK_BITS;
        if (rem > BANK_BITS) return BANK_BITS;
        if (rem < 0)         return 0;
        return rem;
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] level,
    output logic [W-1:0] rise_ev,
    output logic [W-1:0] fall_ev
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level   = sync_q;
    assign rise_ev = sync_q & ~prev_q;
    assign fall_ev = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int BW = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hit,
    input  bank_req_t              req,
    input  logic [BW-1:0]          level,
    input  logic [BW-1:0]          rise_ev,
    input  logic [BW-1:0]          fall_ev,
    output logic [BW-1:0]          out_lvl,
    output logic [BW-1:0]          out_en,
    output logic [BW-1:0]          stat,
    output logic [FN_BITS*BW-1:0]  fn,
    output logic [BANK_BITS-1:0]   rdata
);

    localparam int FN_W = FN_BITS * BW;

    logic [BW-1:0]            dir_q, out_q, rise_q, fall_q, stat_q;
    logic [BW-1:0]            wmask, hit_ev, clr_mask, stat_d;
    logic [FN_W-1:0]          fn_q, fn_d;
    logic [BANK_BITS-1:0]     fn_lo_rd, fn_hi_rd;
    logic                     wr_en;

    assign wr_en    = hit && req.wr;
    assign wmask    = req.data[BW-1:0];
    assign hit_ev   = (rise_ev & rise_q) | (fall_ev & fall_q);
    assign clr_mask = (wr_en && req.code == REG_STAT) ? wmask : '0;
    assign stat_d   = (stat_q & ~clr_mask) | hit_ev;

    // Function fields: pin k lives in half k/16, slot k%16.
    for (genvar k = 0; k < BW; k++) begin : g_fn_pin
        localparam int SLOT = k % FN_SLOTS;
        localparam reg_code_e FCODE = (k < FN_SLOTS) ? REG_FN_LO : REG_FN_HI;
        assign fn_d[FN_BITS*k +: FN_BITS] = (wr_en && req.code == FCODE)
                                          ? req.data[FN_BITS*SLOT +: FN_BITS]
                                          : fn_q[FN_BITS*k +: FN_BITS];
    end

    for (genvar s = 0; s < FN_SLOTS; s++) begin : g_fn_rd
        if (s < BW) begin : g_lo
            assign fn_lo_rd[FN_BITS*s +: FN_BITS] = fn_q[FN_BITS*s +: FN_BITS];
        end else begin : g_lo_nc
            assign fn_lo_rd[FN_BITS*s +: FN_BITS] = '0;
        end
        if (s + FN_SLOTS < BW) begin : g_hi
            assign fn_hi_rd[FN_BITS*s +: FN_BITS] = fn_q[FN_BITS*(s+FN_SLOTS) +: FN_BITS];
        end else begin : g_hi_nc
            assign fn_hi_rd[FN_BITS*s +: FN_BITS] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
            fn_q   <= '0;
        end else begin
            stat_q <= stat_d;
            fn_q   <= fn_d;
            if (wr_en) begin
                case (req.code)
                    REG_DIR:  dir_q  <= wmask;
                    REG_SET:  out_q  <= out_q | wmask;
                    REG_CLR:  out_q  <= out_q & ~wmask;
                    REG_RISE: rise_q <= wmask;
                    REG_FALL: fall_q <= wmask;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (req.code)
            REG_LEVEL: rdata = BANK_BITS'(level);
            REG_DIR:   rdata = BANK_BITS'(dir_q);
            REG_SET,
            REG_CLR:   rdata = BANK_BITS'(out_q);
            REG_RISE:  rdata = BANK_BITS'(rise_q);
            REG_FALL:  rdata = BANK_BITS'(fall_q);
            REG_STAT:  rdata = BANK_BITS'(stat_q);
            REG_FN_LO: rdata = fn_lo_rd;
            REG_FN_HI: rdata = fn_hi_rd;
            default:   rdata = '0;
        endcase
    end

    assign out_lvl = out_q;
    assign out_en  = dir_q;
    assign stat    = stat_q;
    assign fn      = fn_q;

    // R2
    set_drives_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req.code == REG_SET) |=> ((out_q & $past(wmask)) == $past(wmask)));

    // R2
    clr_drives_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req.code == REG_CLR) |=> ((out_q & $past(wmask)) == '0));

    // R7
    stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && req.code == REG_STAT) |=> (($past(stat_q) & ~stat_q) == '0));

    // R8
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req.code == REG_STAT) |=> ((stat_q & $past(hit_ev)) == $past(hit_ev)));

    // R6
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit_ev)) == '0));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int NP = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] stat,
    output logic          irq_pin0,
    output logic          irq_pin1,
    output logic          irq_shared
);

    logic q0, q1, qx;

    always_ff @(posedge clk) begin
        if (rst) begin
            q0 <= 1'b0;
            q1 <= 1'b0;
            qx <= 1'b0;
        end else begin
            q0 <= stat[0];
            q1 <= stat[1];
            qx <= |stat[NP-1:2];
        end
    end

    assign irq_pin0   = q0;
    assign irq_pin1   = q1;
    assign irq_shared = qx;

    // R9
    shared_low_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stat[NP-1:2] == '0) |=> !irq_shared);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BANK_BITS-1:0]    bus_wdata,
    output logic [BANK_BITS-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0]     pin_in,
    output logic [NUM_PINS-1:0]     pin_out,
    output logic [NUM_PINS-1:0]     pin_oe,
    output logic [2*NUM_PINS-1:0]   pin_fn,
    output logic                    irq_pin0,
    output logic                    irq_pin1,
    output logic                    irq_shared
);

    localparam int NBANK = (NUM_PINS + BANK_BITS - 1) / BANK_BITS;

    logic [NUM_PINS-1:0]   lvl, rise_ev, fall_ev, stat_all;
    logic [BANK_SEL_W-1:0] bank_sel;
    logic [BANK_BITS-1:0]  bank_rd [NBANK];
    bank_req_t             req;

    assign bank_sel  = bus_addr[ADDR_W-1 -: BANK_SEL_W];
    assign req.wr    = bus_wr;
    assign req.code  = reg_code_e'(bus_addr[REG_CODE_W-1:0]);
    assign req.data  = bus_wdata;

    gpio_edge_sync #(.W(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .level     (lvl),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int BW = bank_width(NUM_PINS, b);
        localparam int LO = b * BANK_BITS;
        gpio_edge_bank #(.BW(BW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .hit     (bank_sel == BANK_SEL_W'(b)),
            .req     (req),
            .level   (lvl[LO +: BW]),
            .rise_ev (rise_ev[LO +: BW]),
            .fall_ev (fall_ev[LO +: BW]),
            .out_lvl (pin_out[LO +: BW]),
            .out_en  (pin_oe[LO +: BW]),
            .stat    (stat_all[LO +: BW]),
            .fn      (pin_fn[2*LO +: 2*BW]),
            .rdata   (bank_rd[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bank_sel == BANK_SEL_W'(b)) bus_rdata = bank_rd[b];
        end
    end

    gpio_edge_irq #(.NP(NUM_PINS)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .stat       (stat_all),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_shared (irq_shared)
    );

endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 53;

    logic            clk = 1'b0;
    logic            rst;
    logic            bus_wr;
    logic [5:0]      bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in;
    logic [NP-1:0]   pin_out, pin_oe;
    logic [2*NP-1:0] pin_fn;
    logic            irq_pin0, irq_pin1, irq_shared;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference state
    logic [NP-1:0]   m_s1, m_s2, m_s3, m_dir, m_out, m_rise, m_fall, m_stat;
    logic [2*NP-1:0] m_fn;
    logic            m_irq0, m_irq1, m_irqx;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_ctrl #(.NUM_PINS(NP)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .pin_fn     (pin_fn),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_shared (irq_shared)
    );

    task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] ad(int b, int c);
        return {b[1:0], c[3:0]};
    endfunction

    function automatic logic [31:0] model_rd(logic [5:0] a);
        logic [31:0] r;
        int b, c, p;
        r = '0;
        b = int'(a[5:4]);
        c = int'(a[3:0]);
        if (c == 7 || c == 8) begin
            for (int i = 0; i < 16; i++) begin
                p = b * 32 + ((c == 8) ? 16 : 0) + i;
                if (p < NP) r[2*i +: 2] = m_fn[2*p +: 2];
            end
        end else begin
            for (int i = 0; i < 32; i++) begin
                p = b * 32 + i;
                if (p < NP) begin
                    case (c)
                        0: r[i] = m_s2[p];
                        1: r[i] = m_dir[p];
                        2, 3: r[i] = m_out[p];
                        4: r[i] = m_rise[p];
                        5: r[i] = m_fall[p];
                        6: r[i] = m_stat[p];
                        default: r[i] = 1'b0;
                    endcase
                end
            end
        end
        return r;
    endfunction

    function automatic string rd_tag(logic [5:0] a);
        int c;
        c = int'(a[3:0]);
        if (int'(a[5:4]) * 32 >= NP) return "R1";
        case (c)
            0: return "R4";
            1: return "R3";
            2, 3: return "R2";
            4, 5: return "R6";
            6: return "R7";
            7, 8: return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic compare_all();
        check("R2", "pin_out", 128'(pin_out), 128'(m_out));
        check("R3", "pin_oe", 128'(pin_oe), 128'(m_dir));
        check("R5", "pin_fn", 128'(pin_fn), 128'(m_fn));
        check("R9", "irq_pin0", 128'(irq_pin0), 128'(m_irq0));
        check("R9", "irq_pin1", 128'(irq_pin1), 128'(m_irq1));
        check("R9", "irq_shared", 128'(irq_shared), 128'(m_irqx));
        check(rd_tag(bus_addr), "rdata", 128'(bus_rdata), 128'(model_rd(bus_addr)));
    endtask

    task automatic tick();
        logic [NP-1:0] ev, clr;
        int b, c, p;
        @(posedge clk);
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_dir = '0; m_out = '0;
            m_rise = '0; m_fall = '0; m_stat = '0; m_fn = '0;
            m_irq0 = 0; m_irq1 = 0; m_irqx = 0;
        end else begin
            ev  = (m_s2 & ~m_s3 & m_rise) | (~m_s2 & m_s3 & m_fall);
            clr = '0;
            m_irq0 = m_stat[0];
            m_irq1 = m_stat[1];
            m_irqx = |m_stat[NP-1:2];
            if (bus_wr) begin
                b = int'(bus_addr[5:4]);
                c = int'(bus_addr[3:0]);
                for (int i = 0; i < 32; i++) begin
                    p = b * 32 + i;
                    if (p < NP) begin
                        case (c)
                            1: m_dir[p] = bus_wdata[i];
                            2: if (bus_wdata[i]) m_out[p] = 1'b1;
                            3: if (bus_wdata[i]) m_out[p] = 1'b0;
                            4: m_rise[p] = bus_wdata[i];
                            5: m_fall[p] = bus_wdata[i];
                            6: clr[p] = bus_wdata[i];
                            default: ;
                        endcase
                    end
                end
                if (c == 7 || c == 8) begin
                    for (int i = 0; i < 16; i++) begin
                        p = b * 32 + ((c == 8) ? 16 : 0) + i;
                        if (p < NP) m_fn[2*p +: 2] = bus_wdata[2*i +: 2];
                    end
                end
            end
            m_stat = (m_stat & ~clr) | ev;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic bus_write(logic [5:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #1;
        check(tag, "read", 128'(bus_rdata), 128'(exp));
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 40000);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        @(negedge clk);
        ticks(3);
        rst = 1'b0;
        tick();

        // R11 reset state
        rd_chk(ad(0, 1), 32'h0, "R11");
        rd_chk(ad(0, 6), 32'h0, "R11");
        check("R11", "irq_pin0", 128'(irq_pin0), 128'(0));

        // R3 direction
        bus_write(ad(0, 1), 32'h0000_00F0);
        check("R3", "pin_oe[7:4]", 128'(pin_oe[7:4]), 128'(4'hF));

        // R2 set then clear
        bus_write(ad(0, 2), 32'h31);
        bus_write(ad(0, 3), 32'h11);
        check("R2", "pin_out[7:0]", 128'(pin_out[7:0]), 128'(8'h20));
        rd_chk(ad(0, 2), 32'h20, "R2");

        // R10 partial bank
        bus_write(ad(1, 1), 32'hFFFF_FFFF);
        rd_chk(ad(1, 1), 32'h001F_FFFF, "R10");
        check("R10", "pin_oe[52:32]", 128'(pin_oe[52:32]), 128'(21'h1F_FFFF));

        // R1 addressing
        bus_write(ad(1, 2), 32'h100);
        check("R1", "pin_out[40]", 128'(pin_out[40]), 128'(1));
        rd_chk(ad(2, 1), 32'h0, "R1");
        rd_chk(ad(3, 2), 32'h0, "R1");

        // R4 level through synchroniser; writes ignored
        pin_in[5] = 1'b1;
        bus_addr = ad(0, 0);
        tick();
        rd_chk(ad(0, 0), 32'h0, "R4");
        tick();
        rd_chk(ad(0, 0), 32'h20, "R4");
        bus_write(ad(0, 0), 32'h0);
        rd_chk(ad(0, 0), 32'h20, "R4");

        // R5 function fields
        bus_write(ad(0, 7), 32'hC);
        check("R5", "pin_fn[3:2]", 128'(pin_fn[3:2]), 128'(2'b11));
        bus_write(ad(1, 8), 32'hFFFF_FFFF);
        rd_chk(ad(1, 8), 32'h3FF, "R10");
        check("R5", "pin_fn[105:96]", 128'(pin_fn[105:96]), 128'(10'h3FF));

        // R6 rising edge timing
        bus_write(ad(0, 4), 32'h8);
        pin_in[3] = 1'b1;
        ticks(2);
        rd_chk(ad(0, 6), 32'h0, "R6");
        tick();
        rd_chk(ad(0, 6), 32'h8, "R6");
        check("R9", "irq_shared early", 128'(irq_shared), 128'(0));
        tick();
        check("R9", "irq_shared", 128'(irq_shared), 128'(1));

        // R7 write 0 no effect, write 1 clears
        bus_write(ad(0, 6), 32'h0);
        rd_chk(ad(0, 6), 32'h8, "R7");
        bus_write(ad(0, 6), 32'h8);
        rd_chk(ad(0, 6), 32'h0, "R7");
        tick();
        check("R9", "irq_shared cleared", 128'(irq_shared), 128'(0));

        // R6 falling edge
        bus_write(ad(0, 5), 32'h8);
        pin_in[3] = 1'b0;
        ticks(3);
        rd_chk(ad(0, 6), 32'h8, "R6");
        bus_write(ad(0, 6), 32'h8);

        // R9 private lines, both edges on pin 0
        bus_write(ad(0, 4), 32'h3);
        bus_write(ad(0, 5), 32'h1);
        pin_in[0] = 1'b1;
        ticks(4);
        check("R9", "irq_pin0", 128'(irq_pin0), 128'(1));
        check("R9", "irq_pin1", 128'(irq_pin1), 128'(0));
        bus_write(ad(0, 6), 32'h1);
        pin_in[0] = 1'b0;
        ticks(3);
        rd_chk(ad(0, 6), 32'h1, "R6");
        pin_in[1] = 1'b1;
        ticks(4);
        check("R9", "irq_pin1", 128'(irq_pin1), 128'(1));
        bus_write(ad(0, 6), 32'h3);
        tick();
        check("R9", "irq_pin0 clr", 128'(irq_pin0), 128'(0));
        check("R9", "irq_pin1 clr", 128'(irq_pin1), 128'(0));

        // R8 edge coincides with clear
        bus_write(ad(0, 4), 32'h10);
        pin_in[4] = 1'b1;
        ticks(2);
        bus_write(ad(0, 6), 32'h10);
        rd_chk(ad(0, 6), 32'h10, "R8");

        // R6 in the partial bank, pin 50
        bus_write(ad(1, 4), 32'h0004_0000);
        pin_in[50] = 1'b1;
        ticks(3);
        rd_chk(ad(1, 6), 32'h0004_0000, "R6");

        // mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            pin_in = {$urandom, $urandom} & {NP{($urandom % 4) != 0}} ^ pin_in;
            bus_wr = ($urandom % 3) == 0;
            bus_addr = {2'($urandom % 4), 4'($urandom % 10)};
            bus_wdata = $urandom;
            tick();
        end
        bus_wr = 1'b0;

        // R11 reset mid-run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        rd_chk(ad(0, 6), 32'h0, "R11");
        rd_chk(ad(1, 4), 32'h0, "R11");
        check("R11", "pin_oe", 128'(pin_oe), 128'(0));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule